// File: doc/BRIEF.md
# Ping-Pong Coefficient Bank Controller

This block keeps two identical memories of complex gain coefficients for a predistortion datapath. One memory is live and answers every read; the other is a staging copy that an adaptation engine rewrites at its own pace. When the staging copy is complete, a swap request exchanges the two roles in one clock edge, so the datapath moves from the old coefficient set to the new one without a gap and without ever seeing a half-updated table.

The read address is applied to both memories in the same cycle and each memory registers its word. A one-bit role register records which memory is live; a copy of it, captured alongside each read, drives the output multiplexer so that every returned word comes wholly from the memory that was live when the read was issued. Writes carry a target-bank bit, and any write aimed at the live memory is dropped. A swap is taken only in a cycle with no write, which keeps a swap from landing in the middle of an update.

Top module: `coef_pingpong_bank`

## Requirements
- R1: After reset, `active_bank` is 0 (memory 0 live, memory 1 staging) and `rd_data_valid` is 0.
- R2: A read with `rd_valid` high in cycle t returns, after the clock edge ending cycle t, the word stored at `rd_addr` in the memory that was live in cycle t, with `rd_data_valid` high; `rd_data_valid` is low after a cycle with `rd_valid` low.
- R3: A write with `wr_en` high and `wr_bank` equal to the staging memory (`wr_bank` != `active_bank`) stores {`wr_i`,`wr_q`} at `wr_addr` in that memory; it is not seen by reads until after a swap.
- R4: A write whose `wr_bank` equals `active_bank` is dropped: the live memory's contents do not change.
- R5: `swap_req` high with `wr_en` low in a cycle inverts `active_bank` at the next clock edge.
- R6: `swap_req` high in a cycle with `wr_en` high is ignored; `active_bank` does not change and the request is not remembered.
- R7: A read issued in the same cycle as an accepted swap returns data from the memory that was live before the swap; the following read uses the new live memory. No returned word mixes fields of both memories.
- R8: While `rd_valid` is low, `rd_i` and `rd_q` hold the last returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | ADDR_W | Coefficient read address, sent to both memories |
| rd_valid | input | 1 | Read request in this cycle |
| wr_addr | input | ADDR_W | Coefficient write address |
| wr_i | input | COMP_W | In-phase part of the written coefficient |
| wr_q | input | COMP_W | Quadrature part of the written coefficient |
| wr_bank | input | 1 | Memory targeted by the write (0 or 1) |
| wr_en | input | 1 | Write request in this cycle |
| swap_req | input | 1 | Request to exchange live and staging roles |
| rd_i | output | COMP_W | In-phase part of the returned coefficient |
| rd_q | output | COMP_W | Quadrature part of the returned coefficient |
| rd_data_valid | output | 1 | Returned coefficient is valid this cycle |
| active_bank | output | 1 | Index of the live memory |

## Verification
The bench builds the block with ADDR_W=4 and COMP_W=16, so each memory holds 16 entries and every address of both memories can be written and read back in each phase of the test. Each memory gets its own arithmetic pattern and a third pattern is aimed at the live memory, so a misrouted write, a dropped staging write or a wrongly selected output shows up as a value mismatch at a known address. The small depth also lets swaps, refused swaps and reads that coincide with a swap be repeated across the whole address range.

// File: rtl/coef_pp_pkg.sv
package coef_pp_pkg;

    localparam int unsigned NUM_BANKS = 2;

    typedef struct packed {
        logic active;
    } role_state_t;

    typedef struct packed {
        logic sel;
        logic vld;
    } rd_stage_t;

endpackage

// File: rtl/coef_bank_ram.sv
module coef_bank_ram #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/coef_role_ctrl.sv
module coef_role_ctrl
    import coef_pp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_bank,
    input  logic                 swap_req,
    output logic                 active,
    output logic [NUM_BANKS-1:0] bank_we
);
    role_state_t state_d, state_q;
    logic        swap_ok;

    always_comb begin
        state_d = state_q;
        swap_ok = swap_req && !wr_en;
        if (swap_ok) begin
            state_d.active = ~state_q.active;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
        assign bank_we[b] = wr_en && (wr_bank == 1'(b)) && (state_q.active != 1'(b));
    end

    assign active = state_q.active;
endmodule

// File: rtl/coef_read_mux.sv
module coef_read_mux
    import coef_pp_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic              active,
    input  logic [DATA_W-1:0] bank0_data,
    input  logic [DATA_W-1:0] bank1_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sel
);
    rd_stage_t stage_d, stage_q;

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = rd_valid;
        if (rd_valid) begin
            stage_d.sel = active;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_data  = stage_q.sel ? bank1_data : bank0_data;
    assign out_valid = stage_q.vld;
    assign out_sel   = stage_q.sel;
endmodule

// File: rtl/coef_pingpong_bank.sv
module coef_pingpong_bank
    import coef_pp_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned COMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [COMP_W-1:0] wr_i,
    input  logic [COMP_W-1:0] wr_q,
    input  logic              wr_bank,
    input  logic              wr_en,
    input  logic              swap_req,
    output logic [COMP_W-1:0] rd_i,
    output logic [COMP_W-1:0] rd_q,
    output logic              rd_data_valid,
    output logic              active_bank
);
    localparam int unsigned DATA_W = 2 * COMP_W;

    logic [NUM_BANKS-1:0] bank_we;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];
    logic [DATA_W-1:0]    wr_word;
    logic [DATA_W-1:0]    out_word;
    logic                 out_sel;

    assign wr_word = {wr_i, wr_q};

    coef_role_ctrl u_role (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .swap_req (swap_req),
        .active   (active_bank),
        .bank_we  (bank_we)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        coef_bank_ram #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_ram (
            .clk   (clk),
            .we    (bank_we[b]),
            .waddr (wr_addr),
            .wdata (wr_word),
            .re    (rd_valid),
            .raddr (rd_addr),
            .rdata (bank_rdata[b])
        );
    end

    coef_read_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_valid   (rd_valid),
        .active     (active_bank),
        .bank0_data (bank_rdata[0]),
        .bank1_data (bank_rdata[1]),
        .out_data   (out_word),
        .out_valid  (rd_data_valid),
        .out_sel    (out_sel)
    );

    assign rd_i = out_word[DATA_W-1:COMP_W];
    assign rd_q = out_word[COMP_W-1:0];
endmodule

// File: rtl/coef_pingpong_bank_chk.sv
module coef_pingpong_bank_chk #(
    parameter int unsigned COMP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              wr_en,
    input logic              swap_req,
    input logic              active_bank,
    input logic              rd_data_valid,
    input logic [COMP_W-1:0] rd_i,
    input logic [COMP_W-1:0] rd_q,
    input logic [1:0]        bank_we,
    input logic              out_sel
);
    // R2: valid follows the read request by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_data_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rd_data_valid);

    // R4: the live memory never receives a write enable
    a_r4_live_not_written: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we[active_bank]);

    // R5: an accepted swap flips the role bit
    a_r5_swap_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && !wr_en) |=> (active_bank != $past(active_bank)));

    // R6: a swap colliding with a write is refused; no swap request keeps the role
    a_r6_swap_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || !swap_req) |=> $stable(active_bank));

    // R7: output select is the role seen when the read was issued
    a_r7_sel_matches_issue: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (out_sel == $past(active_bank)));

    // R8: outputs hold while no read is issued
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && rd_data_valid) |=> ($stable(rd_i) && $stable(rd_q)));
endmodule

bind coef_pingpong_bank coef_pingpong_bank_chk #(
    .COMP_W (COMP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .wr_en         (wr_en),
    .swap_req      (swap_req),
    .active_bank   (active_bank),
    .rd_data_valid (rd_data_valid),
    .rd_i          (rd_i),
    .rd_q          (rd_q),
    .bank_we       (bank_we),
    .out_sel       (out_sel)
);

// File: tb/coef_pingpong_bank_tb.sv
`timescale 1ns/1ps
module coef_pingpong_bank_tb;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned COMP_W = 16;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [COMP_W-1:0] wr_i = '0;
    logic [COMP_W-1:0] wr_q = '0;
    logic              wr_bank = 1'b0;
    logic              wr_en = 1'b0;
    logic              swap_req = 1'b0;
    logic [COMP_W-1:0] rd_i;
    logic [COMP_W-1:0] rd_q;
    logic              rd_data_valid;
    logic              active_bank;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    coef_pingpong_bank #(.ADDR_W(ADDR_W), .COMP_W(COMP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .wr_addr(wr_addr), .wr_i(wr_i), .wr_q(wr_q), .wr_bank(wr_bank),
        .wr_en(wr_en), .swap_req(swap_req), .rd_i(rd_i), .rd_q(rd_q),
        .rd_data_valid(rd_data_valid), .active_bank(active_bank)
    );

    // pattern 0 for memory 0, 1 for memory 1, 2 for the forbidden writes
    function automatic logic [2*COMP_W-1:0] pat(input int kind, input int a);
        logic [COMP_W-1:0] pi, pq;
        case (kind)
            0:       begin pi = COMP_W'(16'h2000 + a * 91); pq = COMP_W'(~a); end
            1:       begin pi = COMP_W'(16'h1000 + a * 37); pq = COMP_W'(16'hA000 ^ a); end
            default: begin pi = COMP_W'(16'hDEAD ^ a);      pq = COMP_W'(16'hBEEF + a); end
        endcase
        return {pi, pq};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic bank, input int a, input int kind);
        logic [2*COMP_W-1:0] w;
        w = pat(kind, a);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_addr = ADDR_W'(a);
        wr_i = w[2*COMP_W-1:COMP_W]; wr_q = w[COMP_W-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input string req, input int a, input int kind);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = ADDR_W'(a);
        @(negedge clk);
        rd_valid = 1'b0;
        check(req, 64'(rd_data_valid), 64'd1);
        check(req, 64'({rd_i, rd_q}), 64'(pat(kind, a)));
    endtask

    task automatic swap_pulse(input logic with_write);
        @(negedge clk);
        swap_req = 1'b1; wr_en = with_write;
        wr_bank = ~active_bank; wr_addr = '0;
        wr_i = pat(with_write ? 1 : 0, 0) >> COMP_W; wr_q = '0;
        @(negedge clk);
        swap_req = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2*COMP_W-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 active after reset", 64'(active_bank), 64'd0);
        check("R1 valid after reset", 64'(rd_data_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 active held", 64'(active_bank), 64'd0);

        // R3: fill the staging memory 1 with pattern 1
        for (int a = 0; a < DEPTH; a++) write_word(1'b1, a, 1);
        // R5: plain swap makes memory 1 live
        swap_pulse(1'b0);
        check("R5 swap to 1", 64'(active_bank), 64'd1);
        // R3: now fill memory 0 (staging) with pattern 0
        for (int a = 0; a < DEPTH; a++) write_word(1'b0, a, 0);
        // R2/R3: memory 1 content visible, memory 0 writes invisible
        for (int a = 0; a < DEPTH; a++) read_check("R3 staging writes hidden", a, 1);
        // R4: writes aimed at the live memory 1 are dropped
        for (int a = 0; a < DEPTH; a++) write_word(1'b1, a, 2);
        for (int a = DEPTH - 1; a >= 0; a--) read_check("R4 live memory unchanged", a, 1);

        // R6: swap colliding with a write is refused and not remembered
        swap_pulse(1'b1);
        check("R6 refused swap", 64'(active_bank), 64'd1);
        @(negedge clk);
        check("R6 not remembered", 64'(active_bank), 64'd1);
        // the collision write went to memory 0 address 0 with pattern 1 I part; restore
        write_word(1'b0, 0, 0);

        // R5: swap back, memory 0 content now visible
        swap_pulse(1'b0);
        check("R5 swap to 0", 64'(active_bank), 64'd0);
        for (int a = 0; a < DEPTH; a++) read_check("R2 read memory 0", a, 0);

        // R7: reads issued in a swap cycle come from the old live memory
        for (int a = 0; a < DEPTH; a++) begin
            logic old;
            old = active_bank;
            @(negedge clk);
            rd_valid = 1'b1; rd_addr = ADDR_W'(a); swap_req = 1'b1;
            @(negedge clk);
            rd_valid = 1'b0; swap_req = 1'b0;
            check("R7 old memory on swap read", 64'({rd_i, rd_q}), 64'(pat(old ? 1 : 0, a)));
            check("R7 role flipped", 64'(active_bank), 64'(!old));
            read_check("R7 next read from new memory", a, old ? 0 : 1);
        end

        // R8: output holds across idle cycles
        read_check("R8 setup read", 5, int'(active_bank));
        held = {rd_i, rd_q};
        rd_addr = 4'd9;
        repeat (4) begin
            @(negedge clk);
            check("R8 output held", 64'({rd_i, rd_q}), 64'(held));
            check("R2 valid low when idle", 64'(rd_data_valid), 64'd0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule